// File: doc/BRIEF.md
# Variable-Width Target Branch Buffer

This block is a small set-associative branch target buffer. Each of its four ways is a group with a fixed target field width, and the four widths differ. An entry does not hold a full target address. It holds only the low-order bits in which the target differs from the branch address, so the field in each way can be narrower than a full address.

When a branch is written in, the block XORs the branch address with its target. It then finds the highest set bit of that XOR to get the length of the differing segment, and places the branch in a way whose field can hold that many bits. On lookup, the block takes the bits of the lookup address above the hitting way's field width and appends the stored segment, which gives the predicted target.

A branch whose segment is too long for every way is never stored. Because long branches can only use the wide ways, those ways can fill up while the narrow ways stay lightly used.

Top module: `vebtb`

## Requirements
- R1: After reset, no entry is valid and every lookup reports a miss.
- R2: Addresses are byte addresses. The set index is pc[5:2] and the tag is pc[17:6]. A lookup hits when a valid entry in the indexed set carries the same tag. Address bits above bit 17 are not compared.
- R3: The segment length is the index of the highest set bit of (branch XOR target) plus one, or zero when the two are equal. Ways 0 to 3 hold segments of up to 6, 10, 16 and 30 bits.
- R4: An update goes to the narrowest way whose width covers the segment length when that way's entry in the set is empty.
- R5: If that narrowest fitting entry is occupied, the update goes to the narrowest wider way whose entry in the set is empty.
- R6: If every fitting way's entry in the set is occupied, the update overwrites the narrowest fitting way.
- R7: A branch with a segment longer than 30 bits is not installed. Any existing copy of it is still removed.
- R8: On a hit, the target is the lookup address with its bits from the hitting way's width upward kept, and its lower bits replaced by the stored segment.
- R9: At most one way hits for any address. An update to a branch already present removes the old entry. An entry removed in this way counts as empty when the new location is chosen.
- R10: Lookup is combinational. An update takes effect at the clock edge, so a lookup in the same cycle sees the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_target | output | 32 | Predicted target, valid when lk_hit is high |
| upd_valid | input | 1 | Install or refresh a branch this cycle |
| upd_pc | input | 32 | Branch address for the update |
| upd_target | input | 32 | Resolved target for the update |

## Verification
The bench targets segment lengths that sit exactly on a way boundary (6, 10, 16, 30 and 32 bits). A design that counts the segment length off by one would send such a branch to a way one step too wide or too narrow, and the reconstructed target would then disagree with the reference. It fills one set step by step to check the fallback to a wider empty way and the overwrite of the narrowest fitting way once all are full. A wrong choice there would leave the wrong branch resident or evict the wrong one.

It also rewrites a resident branch with a longer target. A design that does not remove the old copy would report two hits or a stale target. Finally, it looks up an address that differs from a resident one only above the tag, which must hit with the upper bits taken from the lookup address.

// File: rtl/vebtb.sv
module vebtb #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  parameter int OFS   = 2,
  parameter int W0    = 6,
  parameter int W1    = 10,
  parameter int W2    = 16,
  parameter int W3    = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target
);
  localparam int NW    = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int LEN_W = $clog2(PC_W + 1);
  localparam int WID [NW] = '{W0, W1, W2, W3};

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [NW-1:0]    lk_hv, up_hv, up_occ, fit, first_fit, wr_way;
  logic [NW*SETS-1:0] vq;
  logic [PC_W-1:0]  way_tgt [NW];
  logic [LEN_W-1:0] seg_len;
  logic             too_long;

  assign lk_idx = lk_pc[OFS +: IDX_W];
  assign up_idx = upd_pc[OFS +: IDX_W];
  assign lk_tag = lk_pc[OFS+IDX_W +: TAG_W];
  assign up_tag = upd_pc[OFS+IDX_W +: TAG_W];

  always_comb begin
    logic [PC_W-1:0] diff;
    diff = upd_pc ^ upd_target;
    seg_len = '0;
    for (int i = 0; i < PC_W; i++)
      if (diff[i]) seg_len = LEN_W'(i + 1);
  end

  for (genvar g = 0; g < NW; g++) begin : g_way
    localparam int W = WID[g];
    logic [SETS-1:0]  v_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [W-1:0]     seg_q [SETS];

    assign vq[g*SETS +: SETS] = v_q;
    assign fit[g]    = 32'(seg_len) <= W;
    assign lk_hv[g]  = v_q[lk_idx] && tag_q[lk_idx] == lk_tag;
    assign up_hv[g]  = v_q[up_idx] && tag_q[up_idx] == up_tag;
    assign up_occ[g] = v_q[up_idx] && !up_hv[g];
    assign way_tgt[g] = {lk_pc[PC_W-1:W], seg_q[lk_idx]};

    always_ff @(posedge clk) begin
      if (!rst_n)
        v_q <= '0;
      else if (wr_way[g])
        v_q[up_idx] <= 1'b1;
      else if (upd_valid && up_hv[g])
        v_q[up_idx] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_way[g]) begin
        tag_q[up_idx] <= up_tag;
        seg_q[up_idx] <= upd_target[W-1:0];
      end
    end
  end

  assign too_long  = !fit[NW-1];
  assign first_fit = fit & ~(fit << 1);

  always_comb begin
    logic found;
    wr_way = '0;
    found  = 1'b0;
    for (int g = 0; g < NW; g++)
      if (!found && fit[g] && !up_occ[g]) begin
        wr_way[g] = 1'b1;
        found = 1'b1;
      end
    if (!found) wr_way = first_fit;
    if (!upd_valid) wr_way = '0;
  end

  always_comb begin
    lk_target = '0;
    for (int g = 0; g < NW; g++)
      if (lk_hv[g]) lk_target = lk_target | way_tgt[g];
  end

  assign lk_hit = |lk_hv;
endmodule

// File: rtl/vebtb_chk.sv
module vebtb_chk #(
  parameter int PC_W = 32,
  parameter int NV   = 64,
  parameter int WMAX = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic [PC_W-1:0] lk_target,
  input logic            upd_valid,
  input logic [3:0]      lk_hv,
  input logic [NV-1:0]   vq,
  input logic            too_long
);
  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hv));

  // R8
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_target[PC_W-1:WMAX] == lk_pc[PC_W-1:WMAX]);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit && vq == '0);

  // R7
  no_long_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && too_long |=> $countones(vq) <= $past($countones(vq)));

  // R4
  one_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> $countones(vq) <= $past($countones(vq)) + 1);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(vq));
endmodule

bind vebtb vebtb_chk #(.PC_W(PC_W), .NV(4*SETS), .WMAX(W3)) chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
  .lk_target(lk_target), .upd_valid(upd_valid), .lk_hv(lk_hv),
  .vq(vq), .too_long(too_long)
);

// File: tb/vebtb_test.sv
`timescale 1ns/1ps
module vebtb_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, upd_pc = 0, upd_target = 0;
  logic upd_valid = 0;
  logic lk_hit;
  logic [31:0] lk_target;
  int compared = 0, mismatched = 0;
  bit done = 0;

  vebtb uut (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_target(lk_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target));

  always #2.5 clk = ~clk;

  int   wd [4] = '{6, 10, 16, 30};
  bit   mv [4][16];
  logic [11:0] mt [4][16];
  logic [31:0] ms [4][16];

  function automatic int seglen(logic [31:0] a, logic [31:0] b);
    int n = 0;
    for (int i = 0; i < 32; i++) if (a[i] ^ b[i]) n = i + 1;
    return n;
  endfunction

  task automatic model_look(input logic [31:0] pc, output bit h, output logic [31:0] t);
    int s = int'(pc[5:2]);
    h = 0; t = 0;
    for (int w = 0; w < 4; w++)
      if (mv[w][s] && mt[w][s] == pc[17:6]) begin
        logic [31:0] m = (32'h1 << wd[w]) - 1;
        h = 1; t = (pc & ~m) | (ms[w][s] & m);
      end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic [31:0] tg);
    int s = int'(pc[5:2]);
    int n = seglen(pc, tg);
    int f = -1, pick = -1;
    for (int w = 0; w < 4; w++)
      if (mv[w][s] && mt[w][s] == pc[17:6]) mv[w][s] = 0;
    for (int w = 3; w >= 0; w--) if (n <= wd[w]) f = w;
    if (f < 0) return;
    for (int w = 3; w >= f; w--) if (!mv[w][s]) pick = w;
    if (pick < 0) pick = f;
    mv[pick][s] = 1; mt[pick][s] = pc[17:6]; ms[pick][s] = tg;
  endtask

  task automatic step(input logic [31:0] lpc, input bit uv,
                      input logic [31:0] upc, input logic [31:0] utg, input string req);
    bit eh; logic [31:0] et;
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_target = utg;
    #1;
    model_look(lpc, eh, et);
    compared++;
    if (lk_hit !== eh || (eh && lk_target !== et)) begin
      mismatched++;
      $display("FAIL %s pc=%h hit=%b tgt=%h expected hit=%b tgt=%h",
               req, lpc, lk_hit, lk_target, eh, et);
    end
    @(posedge clk);
    if (uv) model_update(upc, utg);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 4; w++) for (int s = 0; s < 16; s++) mv[w][s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: empty after reset
    step(32'h1000, 0, 0, 0, "R1");
    step(32'h2004, 0, 0, 0, "R1");
    // R4 R3: boundary lengths, set 0
    step(32'h1000, 1, 32'h1000, 32'h1020, "R10");
    step(32'h1000, 0, 0, 0, "R4");
    step(32'h2000, 1, 32'h2000, 32'h2200, "R3");
    step(32'h3000, 1, 32'h3000, 32'h3000 ^ 32'h8000, "R3");
    step(32'h4000, 1, 32'h4000, 32'h4000 ^ 32'h2000_0000, "R3");
    step(32'h2000, 0, 0, 0, "R8");
    step(32'h3000, 0, 0, 0, "R8");
    step(32'h4000, 0, 0, 0, "R8");
    // R2: alias above tag hits, upper bits from lookup pc
    step(32'h0004_1000, 0, 0, 0, "R2");
    step(32'h0000_1040, 0, 0, 0, "R2");
    // R7: too long
    step(32'h5000, 1, 32'h5000, 32'h8000_5000, "R7");
    step(32'h5000, 0, 0, 0, "R7");
    // R6: set 0 full, short branch overwrites way0
    step(32'h6000, 1, 32'h6000, 32'h6004, "R6");
    step(32'h1000, 0, 0, 0, "R6");
    step(32'h6000, 0, 0, 0, "R6");
    // R5: fallback in set 1
    step(32'h1004, 1, 32'h1004, 32'h1008, "R5");
    step(32'h2004, 1, 32'h2004, 32'h2010, "R5");
    step(32'h1004, 0, 0, 0, "R5");
    step(32'h2004, 0, 0, 0, "R5");
    // R9: move resident branch to wider way
    step(32'h1004, 1, 32'h1004, 32'h1004 ^ 32'h8_0000, "R9");
    step(32'h1004, 0, 0, 0, "R9");
    step(32'h3004, 1, 32'h3004, 32'h3006, "R9");
    step(32'h3004, 0, 0, 0, "R4");
    // R7: long update removes existing copy
    step(32'h2004, 1, 32'h2004, 32'hC000_2004, "R7");
    step(32'h2004, 0, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int wsel [6] = '{4, 6, 10, 16, 30, 32};
      logic [31:0] base, up, tg, lp, m;
      int ws;
      base = {14'($urandom), 12'($urandom_range(0, 5)), 4'($urandom_range(0, 1)), 2'b00};
      up = base;
      ws = wsel[$urandom_range(0, 5)];
      m = (ws == 32) ? 32'hFFFF_FFFF : ((32'h1 << ws) - 1);
      tg = up ^ ($urandom & m);
      lp = {14'($urandom), 12'($urandom_range(0, 5)), 4'($urandom_range(0, 1)), 2'b00};
      step(lp, $urandom_range(0, 2) == 0, up, tg, "R2 R9");
    end
    finish_run();
  end
endmodule